// File: doc/BRIEF.md
# Push-All / Pop-All Stack Sequencer

This block carries out the two bulk stack instructions of a 16-bit x86-class core: saving all eight general registers to the stack, and restoring them. A one-cycle start pulse, together with an opcode select, launches a fixed sequence. First the block spends a fixed number of internal wait cycles. Then it makes eight word accesses through a stack memory port that has a ready handshake. Last, it raises a one-cycle done pulse, in the same cycle as the final stack-pointer write-back to the register file.

When the sequence starts, the stack segment and stack pointer are sampled once. Every address is formed from that sampled pair as segment times sixteen plus offset, giving a 20-bit physical address of the low byte of the word. The register file is reached through one combinational read port, used while saving, and one write port, used while restoring and for the final stack-pointer update.

Top module: `stack_bulk_seq`

## Requirements
- R1: While reset is held and right after it is released, `busy_o`, `done_o`, `mem_req_o` and `rf_wr_en_o` are all low.
- R2: A save (`pop_sel_i`=0) writes the registers in index order 0..7 (0=AX, 1=CX, 2=DX, 3=BX, 4=SP, 5=BP, 6=SI, 7=DI) with `mem_we_o`=1, reading each through `rf_rd_idx_o`. Slot 4 stores the `sp_i` value sampled at start, not the live register.
- R3: Before each save access the working offset drops by 2, modulo 2^16. The access goes to `mem_addr_o` = (SS<<4) + offset, modulo 2^20, where SS and the initial offset are `ss_i` and `sp_i` sampled at start.
- R4: A restore (`pop_sel_i`=1) reads with `mem_we_o`=0 at (SS<<4)+offset, then raises the offset by 2. The words go to registers 7, 6, 5, then a held SP slot, then 3, 2, 1, 0. Each register write happens in the cycle of its accepted read and carries `mem_rdata_i`.
- R5: On a restore, the word read in the fourth slot is written to register 4 only in the done cycle, after register 0 has been written.
- R6: On a save, the only register-file write is register 4, in the done cycle, with the sampled SP minus 16.
- R7: After an accepted start, `busy_o` is high with `mem_req_o` low for exactly 8 cycles (save) or 7 cycles (restore) before the first request.
- R8: A request whose `mem_ready_i` is low stays asserted with an unchanged address. A transfer takes place in a cycle where `mem_req_o` and `mem_ready_i` are both high.
- R9: `done_o` is high for exactly one cycle, the cycle after the eighth transfer. `busy_o` is low in the following cycle.
- R10: A start while `busy_o` is high is ignored: the running sequence keeps its kind, and no further activity follows its done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| pop_sel_i | input | 1 | 0 = save all, 1 = restore all |
| ss_i | input | 16 | Stack segment |
| sp_i | input | 16 | Current stack pointer |
| rf_rd_idx_o | output | 3 | Register-file read index |
| rf_rd_data_i | input | 16 | Register-file read data (combinational) |
| rf_wr_en_o | output | 1 | Register-file write enable |
| rf_wr_idx_o | output | 3 | Register-file write index |
| rf_wr_data_o | output | 16 | Register-file write data |
| mem_req_o | output | 1 | Stack access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 20 | Physical address of the low byte |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with ready |
| mem_ready_i | input | 1 | Access accepted this cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The first request is due exactly 8 (save) or 7 (restore) cycles after the start edge, whatever the ready pattern. The bench counts busy cycles without a request and compares that count when the first transfer is seen. Each restore register write is due in the same cycle as its accepted read, so it is checked against the transfer seen at that same sample point. The done pulse and the SP write-back are due one cycle after the eighth transfer, and busy must be low one cycle later. All observations are taken a fixed delay after the falling edge, once the combinational outputs of the cycle have settled.

// File: rtl/stack_bulk_seq_pkg.sv
package stack_bulk_seq_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_XFER = 2'd2,
      ST_DONE = 2'd3
   } seq_state_e;

   localparam int unsigned GPR_COUNT = 8;
   localparam int unsigned GPR_IDX_W = 3;
   localparam int unsigned SP_GPR    = 4;
endpackage

// File: rtl/stack_bulk_seq_ctrl.sv
module stack_bulk_seq_ctrl
   import stack_bulk_seq_pkg::*;
#(
   parameter int unsigned SLOTS     = 8,
   parameter int unsigned PUSH_WAIT = 8,
   parameter int unsigned POP_WAIT  = 7,
   localparam int unsigned SLOT_W   = $clog2(SLOTS),
   localparam int unsigned MAX_WAIT = (PUSH_WAIT > POP_WAIT) ? PUSH_WAIT : POP_WAIT,
   localparam int unsigned WCNT_W   = $clog2(MAX_WAIT + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              pop_sel_i,
   input  logic              mem_ready_i,
   output logic              load_o,
   output logic              op_pop_o,
   output logic [SLOT_W-1:0] slot_o,
   output logic              xfer_o,
   output logic              mem_req_o,
   output logic              busy_o,
   output logic              done_o
);
   timeunit 1ns;
   timeprecision 100ps;

   seq_state_e        state_q;
   logic [WCNT_W-1:0] wcnt_q;
   logic [WCNT_W-1:0] wait_load;
   logic [SLOT_W-1:0] slot_q;
   logic              op_q;

   // Wait preload: a single constant when both kinds share one count.
   if (PUSH_WAIT == POP_WAIT) begin : g_wait_same
      assign wait_load = WCNT_W'(PUSH_WAIT - 1);
   end else begin : g_wait_split
      assign wait_load = pop_sel_i ? WCNT_W'(POP_WAIT - 1) : WCNT_W'(PUSH_WAIT - 1);
   end

   assign load_o    = (state_q == ST_IDLE) && start_i;
   assign mem_req_o = (state_q == ST_XFER);
   assign xfer_o    = mem_req_o && mem_ready_i;
   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = (state_q == ST_DONE);
   assign op_pop_o  = op_q;
   assign slot_o    = slot_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         wcnt_q  <= '0;
         slot_q  <= '0;
         op_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_WAIT;
                  op_q    <= pop_sel_i;
                  slot_q  <= '0;
                  wcnt_q  <= wait_load;
               end
            end
            ST_WAIT: begin
               if (wcnt_q == '0) state_q <= ST_XFER;
               else              wcnt_q  <= wcnt_q - 1'b1;
            end
            ST_XFER: begin
               if (xfer_o) begin
                  if (slot_q == SLOT_W'(SLOTS - 1)) state_q <= ST_DONE;
                  else                              slot_q  <= slot_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && !mem_ready_i) |=> mem_req_o);

   p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && start_i) |=> $stable(op_pop_o));

endmodule

// File: rtl/stack_bulk_seq_addr.sv
module stack_bulk_seq_addr #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned SEG_SHIFT = 4,
   parameter int unsigned STEP      = 2,
   localparam int unsigned PHYS_W   = DATA_W + SEG_SHIFT
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic              op_pop_i,
   input  logic              req_i,
   input  logic              xfer_i,
   input  logic [DATA_W-1:0] ss_i,
   input  logic [DATA_W-1:0] sp_i,
   output logic [DATA_W-1:0] sp_snap_o,
   output logic [DATA_W-1:0] sp_work_o,
   output logic [PHYS_W-1:0] phys_o
);
   timeunit 1ns;
   timeprecision 100ps;

   logic [DATA_W-1:0] ss_q;
   logic [DATA_W-1:0] snap_q;
   logic [DATA_W-1:0] work_q;
   logic [DATA_W-1:0] offset;
   logic [PHYS_W-1:0] seg_base;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ss_q   <= '0;
         snap_q <= '0;
         work_q <= '0;
      end else if (load_i) begin
         ss_q   <= ss_i;
         snap_q <= sp_i;
         work_q <= sp_i;
      end else if (xfer_i) begin
         work_q <= op_pop_i ? work_q + DATA_W'(STEP) : work_q - DATA_W'(STEP);
      end
   end

   // Save uses the decremented offset, restore uses the current one.
   assign offset = op_pop_i ? work_q : work_q - DATA_W'(STEP);

   if (SEG_SHIFT > 0) begin : g_seg_shift
      assign seg_base = {ss_q, {SEG_SHIFT{1'b0}}};
   end else begin : g_seg_flat
      assign seg_base = ss_q;
   end

   assign phys_o    = seg_base + PHYS_W'(offset);
   assign sp_snap_o = snap_q;
   assign sp_work_o = work_q;

   p_addr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && !xfer_i) |=> $stable(phys_o));

endmodule

// File: rtl/stack_bulk_seq_route.sv
module stack_bulk_seq_route #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned SLOTS    = 8,
   parameter int unsigned SP_SLOT  = 4,
   localparam int unsigned IDX_W   = $clog2(SLOTS),
   localparam int unsigned POP_SP  = SLOTS - 1 - SP_SLOT
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              op_pop_i,
   input  logic [IDX_W-1:0]  slot_i,
   input  logic              xfer_i,
   input  logic              done_i,
   input  logic [DATA_W-1:0] sp_snap_i,
   input  logic [DATA_W-1:0] sp_work_i,
   input  logic [DATA_W-1:0] rf_rd_data_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic [IDX_W-1:0]  rf_rd_idx_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              rf_wr_en_o,
   output logic [IDX_W-1:0]  rf_wr_idx_o,
   output logic [DATA_W-1:0] rf_wr_data_o
);
   timeunit 1ns;
   timeprecision 100ps;

   logic [IDX_W-1:0]  pop_idx;
   logic [DATA_W-1:0] sp_hold_q;

   assign rf_rd_idx_o = slot_i;
   assign pop_idx     = IDX_W'(SLOTS - 1) - slot_i;
   assign mem_wdata_o = (slot_i == IDX_W'(SP_SLOT)) ? sp_snap_i : rf_rd_data_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sp_hold_q <= '0;
      end else if (op_pop_i && xfer_i && (slot_i == IDX_W'(POP_SP))) begin
         sp_hold_q <= mem_rdata_i;
      end
   end

   always_comb begin
      rf_wr_en_o   = 1'b0;
      rf_wr_idx_o  = pop_idx;
      rf_wr_data_o = mem_rdata_i;
      if (done_i) begin
         rf_wr_en_o   = 1'b1;
         rf_wr_idx_o  = IDX_W'(SP_SLOT);
         rf_wr_data_o = op_pop_i ? sp_hold_q : sp_work_i;
      end else if (op_pop_i && xfer_i && (pop_idx != IDX_W'(SP_SLOT))) begin
         rf_wr_en_o   = 1'b1;
      end
   end

   p_sp_after_ax_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_pop_i && rf_wr_en_o && rf_wr_idx_o == IDX_W'(SP_SLOT))
         |-> $past(rf_wr_en_o && rf_wr_idx_o == IDX_W'(0)));

   p_push_rf_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!op_pop_i && rf_wr_en_o) |-> (rf_wr_idx_o == IDX_W'(SP_SLOT)));

endmodule

// File: rtl/stack_bulk_seq.sv
module stack_bulk_seq
   import stack_bulk_seq_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned SEG_SHIFT = 4,
   parameter int unsigned PUSH_WAIT = 8,
   parameter int unsigned POP_WAIT  = 7,
   localparam int unsigned PHYS_W   = DATA_W + SEG_SHIFT,
   localparam int unsigned IDX_W    = GPR_IDX_W,
   localparam int unsigned STEP     = DATA_W / 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              pop_sel_i,
   input  logic [DATA_W-1:0] ss_i,
   input  logic [DATA_W-1:0] sp_i,
   output logic [IDX_W-1:0]  rf_rd_idx_o,
   input  logic [DATA_W-1:0] rf_rd_data_i,
   output logic              rf_wr_en_o,
   output logic [IDX_W-1:0]  rf_wr_idx_o,
   output logic [DATA_W-1:0] rf_wr_data_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [PHYS_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              mem_ready_i,
   output logic              busy_o,
   output logic              done_o
);
   timeunit 1ns;
   timeprecision 100ps;

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
      $error("stack_bulk_seq: DATA_W must be a nonzero multiple of 8");
   end
   if (PUSH_WAIT < 1 || POP_WAIT < 1) begin : g_bad_wait
      $error("stack_bulk_seq: wait counts must be at least 1");
   end
   if ((1 << IDX_W) != GPR_COUNT || SP_GPR >= GPR_COUNT) begin : g_bad_regs
      $error("stack_bulk_seq: register index layout inconsistent");
   end

   logic             load;
   logic             op_pop;
   logic [IDX_W-1:0] slot;
   logic             xfer;
   logic [DATA_W-1:0] sp_snap;
   logic [DATA_W-1:0] sp_work;

   stack_bulk_seq_ctrl #(
      .SLOTS     (GPR_COUNT),
      .PUSH_WAIT (PUSH_WAIT),
      .POP_WAIT  (POP_WAIT)
   ) u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start_i),
      .pop_sel_i   (pop_sel_i),
      .mem_ready_i (mem_ready_i),
      .load_o      (load),
      .op_pop_o    (op_pop),
      .slot_o      (slot),
      .xfer_o      (xfer),
      .mem_req_o   (mem_req_o),
      .busy_o      (busy_o),
      .done_o      (done_o)
   );

   stack_bulk_seq_addr #(
      .DATA_W    (DATA_W),
      .SEG_SHIFT (SEG_SHIFT),
      .STEP      (STEP)
   ) u_addr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load),
      .op_pop_i  (op_pop),
      .req_i     (mem_req_o),
      .xfer_i    (xfer),
      .ss_i      (ss_i),
      .sp_i      (sp_i),
      .sp_snap_o (sp_snap),
      .sp_work_o (sp_work),
      .phys_o    (mem_addr_o)
   );

   stack_bulk_seq_route #(
      .DATA_W  (DATA_W),
      .SLOTS   (GPR_COUNT),
      .SP_SLOT (SP_GPR)
   ) u_route (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .op_pop_i     (op_pop),
      .slot_i       (slot),
      .xfer_i       (xfer),
      .done_i       (done_o),
      .sp_snap_i    (sp_snap),
      .sp_work_i    (sp_work),
      .rf_rd_data_i (rf_rd_data_i),
      .mem_rdata_i  (mem_rdata_i),
      .rf_rd_idx_o  (rf_rd_idx_o),
      .mem_wdata_o  (mem_wdata_o),
      .rf_wr_en_o   (rf_wr_en_o),
      .rf_wr_idx_o  (rf_wr_idx_o),
      .rf_wr_data_o (rf_wr_data_o)
   );

   assign mem_we_o = mem_req_o && !op_pop;

endmodule

// File: tb/stack_bulk_seq_bench.sv
module stack_bulk_seq_bench;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        pop_sel = 1'b0;
   logic [15:0] ss_in = '0;
   logic [2:0]  rf_rd_idx;
   logic [15:0] rf_rd_data;
   logic        rf_wr_en;
   logic [2:0]  rf_wr_idx;
   logic [15:0] rf_wr_data;
   logic        mem_req, mem_we;
   logic [19:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        mem_ready = 1'b0;
   logic        busy, done;

   logic [15:0] regs [8];
   logic [15:0] wmem [int];

   int checks = 0;
   int fails  = 0;

   // operation context shared with the monitor
   bit          mon_on = 0;
   bit          ready_rand = 0;
   bit          cur_pop;
   logic [15:0] sp0;
   logic [19:0] exp_addr [8];
   logic [15:0] exp_wdata [8];
   logic [15:0] pop_words [8];
   int          exp_wait, xk, pre_cnt, pop_wr_cnt;
   bit          ax_seen, prev_last, done_seen, stall_pending;
   logic [19:0] stall_addr;

   assign rf_rd_data = regs[rf_rd_idx];

   always #2.5 clk = ~clk;

   stack_bulk_seq u_stack_bulk_seq (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pop_sel_i(pop_sel),
      .ss_i(ss_in), .sp_i(regs[4]),
      .rf_rd_idx_o(rf_rd_idx), .rf_rd_data_i(rf_rd_data),
      .rf_wr_en_o(rf_wr_en), .rf_wr_idx_o(rf_wr_idx), .rf_wr_data_o(rf_wr_data),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
      .busy_o(busy), .done_o(done)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int pop_idx_of(input int n);
      return (n < 3) ? 7 - n : 6 - n;
   endfunction

   function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
      return {seg, 4'h0} + {4'h0, off};
   endfunction

   task automatic observe();
      if (stall_pending)
         chk(mem_req && mem_addr == stall_addr, "R8 stalled request held", {12'h0, mem_addr}, {12'h0, stall_addr});
      if (prev_last)
         chk(done == 1'b1, "R9 done one cycle after last transfer", 32'(done), 32'd1);
      else if (done)
         chk(1'b0, "R9 done without last transfer", 32'(done), 32'd0);
      prev_last = 1'b0;
      stall_pending = mem_req && !mem_ready;
      stall_addr = mem_addr;
      if (busy && !mem_req && xk == 0) pre_cnt++;
      if (mem_req && mem_ready) begin
         if (xk == 0)
            chk(pre_cnt == exp_wait, "R7 wait cycles before first access", 32'(pre_cnt), 32'(exp_wait));
         if (xk < 8) begin
            if (cur_pop) begin
               chk(mem_addr == exp_addr[xk], "R4 restore address", {12'h0, mem_addr}, {12'h0, exp_addr[xk]});
               chk(!mem_we, "R4 restore access is a read", 32'(mem_we), 32'd0);
            end else begin
               chk(mem_addr == exp_addr[xk], "R3 save address", {12'h0, mem_addr}, {12'h0, exp_addr[xk]});
               chk(mem_we && mem_wdata == exp_wdata[xk], "R2 save data and order",
                   {15'h0, mem_we, mem_wdata}, {16'h1, exp_wdata[xk]});
               wmem[int'(mem_addr)] = mem_wdata;
            end
         end else begin
            chk(1'b0, "R9 transfer beyond eight", 32'(xk), 32'd8);
         end
         xk++;
         if (xk == 8) prev_last = 1'b1;
      end
      if (rf_wr_en) begin
         if (cur_pop) begin
            if (rf_wr_idx == 3'd4) begin
               chk(done && ax_seen, "R5 SP restored last", {30'h0, done, ax_seen}, 32'd3);
               chk(rf_wr_data == pop_words[3], "R5 SP takes fourth popped word", 32'(rf_wr_data), 32'(pop_words[3]));
            end else begin
               chk(int'(rf_wr_idx) == pop_idx_of(pop_wr_cnt), "R4 restore register order",
                   32'(rf_wr_idx), 32'(pop_idx_of(pop_wr_cnt)));
               chk(rf_wr_data == pop_words[7 - int'(rf_wr_idx)], "R4 restore data",
                   32'(rf_wr_data), 32'(pop_words[7 - int'(rf_wr_idx)]));
               if (rf_wr_idx == 3'd0) ax_seen = 1'b1;
               pop_wr_cnt++;
            end
         end else begin
            chk(rf_wr_idx == 3'd4 && done && rf_wr_data == 16'(sp0 - 16'd16), "R6 save final SP write",
                {12'h0, rf_wr_idx, done, rf_wr_data}, {12'h0, 3'd4, 1'b1, 16'(sp0 - 16'd16)});
         end
         regs[rf_wr_idx] = rf_wr_data;
      end
      if (done) done_seen = 1'b1;
   endtask

   // memory responder and monitor
   initial begin
      forever begin
         @(negedge clk);
         mem_ready = ready_rand ? ($urandom_range(0, 2) != 0) : 1'b1;
         mem_rdata = wmem.exists(int'(mem_addr)) ? wmem[int'(mem_addr)] : 16'hDEAD;
         #1;
         if (mon_on) observe();
      end
   end

   task automatic run_op(input bit pop, input logic [15:0] ss, input logic [15:0] sp,
                         input bit perturb, input bit inject);
      for (int i = 0; i < 8; i++) regs[i] = 16'($urandom);
      regs[4] = sp;
      sp0 = sp;
      cur_pop = pop;
      exp_wait = pop ? 7 : 8;
      for (int k = 0; k < 8; k++) begin
         if (pop) begin
            exp_addr[k]  = phys(ss, 16'(sp + 16'(2 * k)));
            pop_words[k] = 16'($urandom);
            wmem[int'(exp_addr[k])] = pop_words[k];
         end else begin
            exp_addr[k]  = phys(ss, 16'(sp - 16'(2 * (k + 1))));
            exp_wdata[k] = (k == 4) ? sp : regs[k];
         end
      end
      xk = 0; pre_cnt = 0; pop_wr_cnt = 0;
      ax_seen = 0; prev_last = 0; done_seen = 0; stall_pending = 0;
      @(negedge clk);
      start = 1'b1; pop_sel = pop; ss_in = ss;
      mon_on = 1'b1;
      @(negedge clk);
      start = 1'b0; pop_sel = 1'($urandom); ss_in = 16'($urandom);
      if (perturb) regs[4] = 16'($urandom);
      if (inject) begin
         repeat (3) @(negedge clk);
         start = 1'b1; pop_sel = ~pop;
         @(negedge clk);
         start = 1'b0;
      end
      for (int c = 0; c < 3000 && !done_seen; c++) @(negedge clk);
      if (!done_seen) chk(1'b0, "R9 done never seen", 32'd0, 32'd1);
      @(negedge clk);
      #1;
      mon_on = 1'b0;
      chk(!busy && !done, "R9 idle after done", {30'h0, busy, done}, 32'd0);
      if (inject) begin
         for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            #1;
            chk(!busy && !mem_req, "R10 ignored start caused no restart", {30'h0, busy, mem_req}, 32'd0);
         end
      end
      if (pop) begin
         for (int k = 0; k < 8; k++)
            chk(regs[(k == 3) ? 4 : 7 - k] == pop_words[k], "R4 register file after restore",
                32'(regs[(k == 3) ? 4 : 7 - k]), 32'(pop_words[k]));
      end else begin
         chk(regs[4] == 16'(sp0 - 16'd16), "R6 SP after save", 32'(regs[4]), 32'(16'(sp0 - 16'd16)));
      end
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R9 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 8; i++) regs[i] = '0;
      repeat (3) @(negedge clk);
      #1;
      chk(!busy && !done && !mem_req && !rf_wr_en, "R1 outputs during reset",
          {28'h0, busy, done, mem_req, rf_wr_en}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(!busy && !done && !mem_req && !rf_wr_en, "R1 outputs after reset",
          {28'h0, busy, done, mem_req, rf_wr_en}, 32'd0);

      // directed corners
      ready_rand = 0;
      run_op(1'b0, 16'h2000, 16'h1000, 1'b0, 1'b0);
      run_op(1'b1, 16'h2000, 16'h0FF0, 1'b0, 1'b0);
      run_op(1'b0, 16'h0100, 16'h0006, 1'b1, 1'b0);   // R3 offset wraps below zero
      run_op(1'b0, 16'hFFF8, 16'hFFF0, 1'b0, 1'b0);   // R3 physical wrap at 2^20
      run_op(1'b1, 16'h0040, 16'hFFFA, 1'b0, 1'b0);   // R4 offset wraps above 0xFFFF
      run_op(1'b0, 16'h1234, 16'h8000, 1'b0, 1'b1);   // R10 start during save
      run_op(1'b1, 16'h4321, 16'h7000, 1'b0, 1'b1);   // R10 start during restore

      // constrained random with stalls (R8)
      for (int n = 0; n < 40; n++) begin
         ready_rand = (n % 3) != 0;
         run_op(1'($urandom), 16'($urandom), 16'($urandom), 1'($urandom), (n % 7) == 3);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule